// File: doc/BRIEF.md
# Synchronous Burst SRAM Bank

A cycle-accurate, synthesizable model of one bank of a flow-through synchronous burst SRAM. On each rising clock edge the bank samples its address, its select, two start strobes, the step control, the write controls and the write data. Read data flows through with no output register. The first word of a burst appears in the cycle after the edge that loads the address, and each following word appears one cycle after the step that selects it, which gives a 2-1-1-1 access pattern.

The word is 72 bits wide and is split into eight 9-bit lanes. Lane i holds data byte `dq[8i+7:8i]` and parity bit `dq[64+i]`. A 2-bit beat counter rewrites only the two lowest address bits and can follow either a linear or an interleaved order. There are two start strobes. One always begins a read. The other begins a read or a write depending on the write controls, or deselects the bank. The data bus is modelled as a data vector plus a drive flag: drive low stands for high impedance. The output enable acts without a clock. A standby input freezes the bank and floats its outputs.

Top module: `sram_bank`

## Requirements
- R1: While reset is high, and in the cycle after it, `dq_drive` is 0.
- R2: `rd_go_n`=0 with `sel_n`=0 loads `addr` and starts a read, whatever the write controls are. After that edge `dq_out` shows the word at `addr`, `dq_drive` is high (output enable low), and nothing is written.
- R3: `ctl_go_n`=0, when R2 does not apply and `sel_n`=0, loads `addr`. It writes the input word if `wr_all_n`=0 or if `wr_lane_n`=0 with any `lane_en_n` bit at 0. Otherwise it starts a read.
- R4: `ctl_go_n`=0 with `sel_n`=1, when R2 does not apply, deselects the bank, and `dq_drive` goes to 0 after that edge.
- R5: With both start strobes high during a burst, `step_n`=0 moves to the next burst address and `step_n`=1 keeps the current address. In either case the write controls of that cycle decide whether the cycle reads or writes.
- R6: With `il_order`=0 the low two address bits run start, start+1, start+2, start+3, modulo 4. The upper bits never change.
- R7: With `il_order`=1 the low two address bits are the start offset XOR the beat count 0,1,2,3.
- R8: `wr_all_n`=0 writes all 72 bits, whatever `wr_lane_n` and `lane_en_n` are.
- R9: With `wr_all_n`=1 and `wr_lane_n`=0, lane i (bits [8i+7:8i] and bit 64+i) is written exactly when `lane_en_n[i]`=0. The other lanes keep their contents.
- R10: `out_en_n`=1 forces `dq_drive` to 0 in the same cycle, without waiting for a clock edge. Bursts go on advancing while it is high.
- R11: While `standby`=1 the bank ignores starts, steps and writes, keeps its burst state, and holds `dq_drive` at 0.
- R12: Continue and suspend cycles still act when `sel_n` has since gone high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW | External word address |
| sel_n | input | 1 | Bank select, active low |
| rd_go_n | input | 1 | Start strobe that always begins a read, active low |
| ctl_go_n | input | 1 | Start strobe that follows the write controls, active low |
| step_n | input | 1 | Advance the burst when low, hold it when high |
| wr_all_n | input | 1 | Full-word write, active low |
| wr_lane_n | input | 1 | Gate for per-lane writes, active low |
| lane_en_n | input | 8 | Per-lane write enables, active low |
| il_order | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Output enable, active low, unclocked |
| standby | input | 1 | Low-power standby, active high |
| dq_in | input | 72 | Write data, captured with the address |
| dq_out | output | 72 | Read data at the current burst address |
| dq_drive | output | 1 | Bus driven when 1, high impedance when 0 |

## Verification
The bench tries a linear burst and an interleaved burst from the same odd start offset. At an odd offset the two orders give different sequences, so a counter that ignores the order input is caught. Bursts that mix steps and suspends tell a working step control from one that always advances or always holds. Lane writes with a sparse mask, next to a full-word write whose lane enables are all inactive, separate the per-lane path from the override. Starts issued with the write controls active, with the bank deselected, with the output enable high and during standby each show whether the strobe priority and the float conditions are right.

// File: rtl/sram_bank_pkg.sv
package sram_bank_pkg;
  localparam int LANES  = 8;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // Action taken at the coming clock edge
  typedef enum logic [2:0] {
    OP_NONE,    // nothing changes
    OP_RD_GO,   // load address, forced read
    OP_CTL_GO,  // load address, read or write
    OP_DESEL,   // end the burst, float the bus
    OP_STEP,    // move to the next beat
    OP_HOLD     // stay on the current beat
  } op_e;
endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import sram_bank_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  op_e           op,
  input  logic [AW-1:0] ext_addr,
  input  logic          il_order,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr
);
  logic [AW-1:0] base_q;
  logic [1:0]    beat_q;

  function automatic logic [1:0] low_bits(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       il);
    return il ? (start ^ beat) : (start + beat);
  endfunction

  assign cur_addr = {base_q[AW-1:2], low_bits(base_q[1:0], beat_q, il_order)};

  always_comb begin
    case (op)
      OP_RD_GO, OP_CTL_GO: nxt_addr = ext_addr;
      OP_STEP: nxt_addr = {base_q[AW-1:2],
                           low_bits(base_q[1:0], beat_q + 2'd1, il_order)};
      default: nxt_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else begin
      case (op)
        OP_RD_GO, OP_CTL_GO: begin
          base_q <= ext_addr;
          beat_q <= '0;
        end
        OP_STEP: beat_q <= beat_q + 2'd1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int AW = 6,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import sram_bank_pkg::*;
#(
  parameter int NL = LANES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          standby,
  input  logic          sel_n,
  input  logic          rd_go_n,
  input  logic          ctl_go_n,
  input  logic          step_n,
  input  logic          wr_all_n,
  input  logic          wr_lane_n,
  input  logic [NL-1:0] lane_en_n,
  input  logic          out_en_n,
  output op_e           op,
  output logic [NL-1:0] lane_we,
  output logic          dq_drive
);
  logic          active_q;
  logic          rd_q;
  logic [NL-1:0] wmask;

  always_comb begin
    if (standby)                    op = OP_NONE;
    else if (!rd_go_n && !sel_n)    op = OP_RD_GO;
    else if (!ctl_go_n)             op = sel_n ? OP_DESEL : OP_CTL_GO;
    else if (active_q)              op = step_n ? OP_HOLD : OP_STEP;
    else                            op = OP_NONE;
  end

  always_comb begin
    if (!wr_all_n)       wmask = '1;
    else if (!wr_lane_n) wmask = ~lane_en_n;
    else                 wmask = '0;
  end

  assign lane_we = (op == OP_CTL_GO || op == OP_STEP || op == OP_HOLD) ? wmask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      case (op)
        OP_RD_GO: begin
          active_q <= 1'b1;
          rd_q     <= 1'b1;
        end
        OP_CTL_GO: begin
          active_q <= 1'b1;
          rd_q     <= (wmask == '0);
        end
        OP_DESEL: begin
          active_q <= 1'b0;
          rd_q     <= 1'b0;
        end
        OP_STEP, OP_HOLD: rd_q <= (wmask == '0);
        default: ;
      endcase
    end
  end

  assign dq_drive = active_q && rd_q && !out_en_n && !standby;
endmodule

// File: rtl/sram_bank.sv
module sram_bank
  import sram_bank_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic              sel_n,
  input  logic              rd_go_n,
  input  logic              ctl_go_n,
  input  logic              step_n,
  input  logic              wr_all_n,
  input  logic              wr_lane_n,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic              il_order,
  input  logic              out_en_n,
  input  logic              standby,
  input  logic [WORD_W-1:0] dq_in,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_drive
);
  localparam int DATA_W = 8 * LANES;

  op_e              op;
  logic [LANES-1:0] lane_we;
  logic [AW-1:0]    cur_addr;
  logic [AW-1:0]    nxt_addr;

  bank_ctrl #(.NL(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .standby(standby), .sel_n(sel_n),
    .rd_go_n(rd_go_n), .ctl_go_n(ctl_go_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n), .lane_en_n(lane_en_n),
    .out_en_n(out_en_n), .op(op), .lane_we(lane_we), .dq_drive(dq_drive)
  );

  burst_addr_gen #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .op(op), .ext_addr(addr), .il_order(il_order),
    .cur_addr(cur_addr), .nxt_addr(nxt_addr)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] rd;
    sram_lane #(.AW(AW), .W(LANE_W)) u_lane (
      .clk(clk), .we(lane_we[i]), .waddr(nxt_addr),
      .wdata({dq_in[DATA_W+i], dq_in[8*i +: 8]}),
      .raddr(cur_addr), .rdata(rd)
    );
    assign dq_out[8*i +: 8]   = rd[7:0];
    assign dq_out[DATA_W + i] = rd[8];
  end
endmodule

// File: rtl/sram_bank_chk.sv
module sram_bank_chk
  import sram_bank_pkg::*;
#(
  parameter int AW = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_n,
  input logic              rd_go_n,
  input logic              ctl_go_n,
  input logic              step_n,
  input logic              wr_all_n,
  input logic              wr_lane_n,
  input logic              out_en_n,
  input logic              standby,
  input logic [WORD_W-1:0] dq_out,
  input logic              dq_drive
);
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !dq_drive);

  assert_read_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!standby && !rd_go_n && !sel_n) |=> (dq_drive || out_en_n || standby));

  assert_deselect_R4: assert property (@(posedge clk) disable iff (rst)
    (!standby && !ctl_go_n && sel_n) |=> !dq_drive);

  assert_suspend_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!standby && rd_go_n && ctl_go_n && step_n && wr_all_n && wr_lane_n)
      |=> $stable(dq_out));

  assert_oe_float_R10: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !dq_drive);

  assert_standby_float_R11: assert property (@(posedge clk) disable iff (rst)
    standby |-> !dq_drive);
endmodule

bind sram_bank sram_bank_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .sel_n(sel_n), .rd_go_n(rd_go_n), .ctl_go_n(ctl_go_n),
  .step_n(step_n), .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n),
  .out_en_n(out_en_n), .standby(standby), .dq_out(dq_out), .dq_drive(dq_drive)
);

// File: tb/sram_bank_test.sv
module sram_bank_test;
  localparam int AW = 6;
  localparam int W  = 72;

  logic          clk = 0;
  logic          rst = 1;
  logic [AW-1:0] addr = '0;
  logic          sel_n = 0, rd_go_n = 1, ctl_go_n = 1, step_n = 1;
  logic          wr_all_n = 1, wr_lane_n = 1;
  logic [7:0]    lane_en_n = '1;
  logic          il_order = 0, out_en_n = 0, standby = 0;
  logic [W-1:0]  dq_in = '0;
  logic [W-1:0]  dq_out;
  logic          dq_drive;

  int checks = 0, errors = 0;
  logic [W-1:0] ref_m [64];

  sram_bank #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .addr(addr), .sel_n(sel_n), .rd_go_n(rd_go_n),
    .ctl_go_n(ctl_go_n), .step_n(step_n), .wr_all_n(wr_all_n),
    .wr_lane_n(wr_lane_n), .lane_en_n(lane_en_n), .il_order(il_order),
    .out_en_n(out_en_n), .standby(standby), .dq_in(dq_in),
    .dq_out(dq_out), .dq_drive(dq_drive)
  );

  always #10 clk = ~clk;

  function automatic logic [W-1:0] pat(input int a);
    logic [7:0] b = 8'(a);
    return {b ^ 8'h5A, {8{b + 8'h11}} ^ 64'h0123_4567_89AB_CDEF};
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    rd_go_n = 1; ctl_go_n = 1; step_n = 1; wr_all_n = 1; wr_lane_n = 1;
    lane_en_n = '1; sel_n = 0;
  endtask

  // Full-word write burst of four beats starting at a, linear order
  task automatic fill4(input int a);
    idle(); il_order = 0;
    ctl_go_n = 0; addr = AW'(a); wr_all_n = 0; dq_in = pat(a);
    cyc(); ref_m[a] = pat(a);
    ctl_go_n = 1; step_n = 0;
    for (int k = 1; k < 4; k++) begin
      int x = (a & ~3) | ((a + k) & 3);
      dq_in = pat(x); cyc(); ref_m[x] = pat(x);
    end
    idle();
  endtask

  task automatic rd_start(input int a, input string req);
    idle(); rd_go_n = 0; addr = AW'(a);
    cyc(); idle();
    chk(req, W'(dq_drive), W'(1));
    chk(req, dq_out, ref_m[a]);
  endtask

  task automatic step_chk(input int a, input string req);
    step_n = 0; cyc(); step_n = 1;
    chk(req, W'(dq_drive), W'(1));
    chk(req, dq_out, ref_m[a]);
  endtask

  task automatic t_reset();
    chk("R1", W'(dq_drive), W'(0));
    rst = 0; cyc();
    chk("R1", W'(dq_drive), W'(0));
  endtask

  task automatic t_linear();
    fill4(8);
    il_order = 0;
    rd_start(9, "R6");
    step_chk(10, "R6"); step_chk(11, "R6"); step_chk(8, "R6");
  endtask

  task automatic t_interleave();
    fill4(12);
    il_order = 1;
    rd_start(13, "R7");
    step_chk(12, "R7"); step_chk(15, "R7"); step_chk(14, "R7");
    il_order = 0;
  endtask

  task automatic t_suspend();
    rd_start(8, "R5");
    cyc(); chk("R5", dq_out, ref_m[8]);
    step_chk(9, "R5");
    cyc(); cyc(); chk("R5", dq_out, ref_m[9]);
  endtask

  task automatic t_rd_forced();
    // write controls active with the read strobe: no write happens
    idle(); rd_go_n = 0; ctl_go_n = 0; addr = 6'd10; wr_all_n = 0; dq_in = '1;
    cyc(); idle();
    chk("R2", W'(dq_drive), W'(1));
    chk("R2", dq_out, ref_m[10]);
    rd_start(10, "R2");
  endtask

  task automatic t_lanes();
    logic [W-1:0] e;
    idle(); ctl_go_n = 0; addr = 6'd20; wr_all_n = 0; dq_in = pat(20);
    cyc(); ref_m[20] = pat(20); idle();
    ctl_go_n = 0; addr = 6'd20; wr_lane_n = 0; lane_en_n = 8'b1010_0101;
    dq_in = ~pat(20);
    cyc(); idle();
    chk("R3", W'(dq_drive), W'(0));
    e = ref_m[20];
    for (int i = 0; i < 8; i++) begin
      if (i == 1 || i == 3 || i == 4 || i == 6) begin
        e[8*i +: 8] = ~ref_m[20][8*i +: 8];
        e[64+i]     = ~ref_m[20][64+i];
      end
    end
    ref_m[20] = e;
    rd_start(20, "R9");
  endtask

  task automatic t_override();
    idle(); ctl_go_n = 0; addr = 6'd21; wr_all_n = 0; wr_lane_n = 0;
    lane_en_n = '1; dq_in = pat(99);
    cyc(); ref_m[21] = pat(99); idle();
    rd_start(21, "R8");
  endtask

  task automatic t_ctl_read();
    // control strobe with write controls inactive: single read
    idle(); ctl_go_n = 0; addr = 6'd21; dq_in = '0;
    cyc(); idle();
    chk("R3", W'(dq_drive), W'(1));
    chk("R3", dq_out, ref_m[21]);
  endtask

  task automatic t_desel();
    rd_start(8, "R4");
    ctl_go_n = 0; sel_n = 1;
    cyc(); idle();
    chk("R4", W'(dq_drive), W'(0));
    step_n = 0; cyc(); idle();
    chk("R4", W'(dq_drive), W'(0));
  endtask

  task automatic t_sel_latched();
    rd_start(12, "R12");
    sel_n = 1;
    step_n = 0; cyc(); step_n = 1;
    chk("R12", W'(dq_drive), W'(1));
    chk("R12", dq_out, ref_m[13]);
    sel_n = 0;
  endtask

  task automatic t_oe();
    rd_start(8, "R10");
    #2 out_en_n = 1; #1;
    chk("R10", W'(dq_drive), W'(0));
    step_n = 0; cyc(); cyc(); step_n = 1;
    chk("R10", W'(dq_drive), W'(0));
    out_en_n = 0; #1;
    chk("R10", W'(dq_drive), W'(1));
    chk("R10", dq_out, ref_m[10]);
  endtask

  task automatic t_standby();
    rd_start(9, "R11");
    standby = 1; #1;
    chk("R11", W'(dq_drive), W'(0));
    rd_go_n = 0; addr = 6'd20; cyc();
    rd_go_n = 1; step_n = 0; wr_all_n = 0; dq_in = '0; cyc(); idle();
    chk("R11", W'(dq_drive), W'(0));
    standby = 0; #1;
    chk("R11", W'(dq_drive), W'(1));
    chk("R11", dq_out, ref_m[9]);
    step_chk(10, "R11");
  endtask

  initial begin
    repeat (3) cyc();
    t_reset();
    t_linear();
    t_interleave();
    t_suspend();
    t_rd_forced();
    t_lanes();
    t_override();
    t_ctl_read();
    t_desel();
    t_sel_latched();
    t_oe();
    t_standby();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule